// File: doc/BRIEF.md
# Sleep Mode Wake Controller

This block sequences the power state of a low-power wireless microcontroller. Software asks for one of four sleep states by pulsing a request with a mode code. The controller then drives the core power-domain enable, the peripheral reset and the sleep-timer enable to suit that state. It drops the run indication while the system sleeps.

On entry the controller takes a snapshot of the GPIO bus, the two serial-controller pins and the external interrupt line. While asleep it compares the live inputs against that snapshot. It also watches the two debug power-up request bits and the three sleep-timer events, and keeps only the sources that are valid for the current state. When a valid source fires, the controller records every source that fired in a write-one-to-clear status register. After a deep state it powers the core back up and waits a programmable settle count before it releases reset and reports run. A small configuration register also holds the enables for the 32 kHz crystal and the 10 kHz RC clock used during deep sleep.

Top module: `pwr_sleep_seq`

## Requirements
- R1: After reset, cpu_run=1, core_pwr_en=1, periph_rst=0, sleep_tmr_en=1, wake_status=0, xtal32k_en=0 and rc10k_en=0.
- R2: A request with mode 0 (idle) while running clears cpu_run on the next cycle and leaves core_pwr_en=1 and periph_rst=0. Only irq_pending wakes idle. It returns to run one cycle after the event, with no settle phase.
- R3: Mode 1 (emulated deep sleep) keeps core_pwr_en=1 and sleep_tmr_en=1 and sets periph_rst=1. It wakes on any pin, debug or timer source, but not on irq_pending.
- R4: Mode 2 (deep sleep 1) drives core_pwr_en=0, periph_rst=1 and sleep_tmr_en=1. Timer compare A, compare B and wrap wake it.
- R5: Mode 3 (deep sleep 2) drives core_pwr_en=0 and sleep_tmr_en=0. Timer events neither wake it nor set status bits.
- R6: The GPIO bus (any bit), serial pin 1, serial pin 2 and the external interrupt line wake the system only when they differ from their values captured at sleep entry. A level held steady since entry does not wake.
- R7: dbg_pwrup_req and sys_pwrup_req wake any deep state on a high level. This includes a level that was already high at entry.
- R8: On the wake cycle, wake_status gains a one for every valid source that fired. The bit positions are: 0 GPIO, 1 serial pin 1, 2 serial pin 2, 3 external interrupt, 4 debug request, 5 system request, 6 compare A, 7 compare B, 8 wrap, 9 idle interrupt.
- R9: A stat_clr_wr pulse clears the wake_status bits that are one in stat_clr_data and leaves the others. A bit set in the same cycle stays set.
- R10: After a deep-state wake, core_pwr_en=1 and periph_rst=1 last for exactly settle_cnt+1 cycles, using settle_cnt as sampled on the wake cycle. Then cpu_run=1 and periph_rst=0.
- R11: A request with mode 4 to 7 is ignored and the controller stays in run.
- R12: A clk_cfg_wr pulse loads clk_cfg_wdata. Bit 0 drives xtal32k_en and bit 1 drives rc10k_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle sleep request |
| sleep_mode | input | 3 | Requested state: 0 idle, 1 emulated, 2 deep 1, 3 deep 2 |
| settle_cnt | input | SETTLE_W | Settle length after a deep wake |
| gpio_in | input | GPIO_W | GPIO bus |
| ser1_pin | input | 1 | Serial controller 1 pin |
| ser2_pin | input | 1 | Serial controller 2 pin |
| ext_irq | input | 1 | External interrupt line |
| dbg_pwrup_req | input | 1 | Debug power-up request bit |
| sys_pwrup_req | input | 1 | System power-up request bit |
| tmr_cmp_a | input | 1 | Sleep timer compare A event |
| tmr_cmp_b | input | 1 | Sleep timer compare B event |
| tmr_wrap | input | 1 | Sleep timer wrap event |
| irq_pending | input | 1 | Any interrupt pending (idle wake) |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_data | input | 10 | Ones select status bits to clear |
| clk_cfg_wr | input | 1 | Clock configuration write strobe |
| clk_cfg_wdata | input | 2 | Clock configuration data |
| wake_status | output | 10 | Sticky wake source flags |
| core_pwr_en | output | 1 | Core power-domain enable |
| periph_rst | output | 1 | Peripheral reset, debug logic excluded |
| sleep_tmr_en | output | 1 | Sleep timer enable |
| cpu_run | output | 1 | System running |
| xtal32k_en | output | 1 | 32 kHz crystal enable |
| rc10k_en | output | 1 | 10 kHz RC enable in deep sleep |

## Verification
The bench fires timer events in deep sleep 2, alone and together with a valid source. A design that did not mask them would wake, or would record bits 6 to 8 next to the real cause. It holds a serial pin high across sleep entry and then drops it. A level-sensitive detector would wake at once, and one with no snapshot would never wake. A debug request that is already high at entry must still wake the system. The bench also counts the settle cycles while it changes settle_cnt during the settle phase, which exposes an off-by-one or an unlatched count. It clears status in the same cycle as a wake, so a clear that wins over the set would lose the wake cause.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  localparam int NSRC = 10;

  localparam int SRC_GPIO = 0;
  localparam int SRC_SER1 = 1;
  localparam int SRC_SER2 = 2;
  localparam int SRC_EXTI = 3;
  localparam int SRC_DBG  = 4;
  localparam int SRC_SYS  = 5;
  localparam int SRC_CMPA = 6;
  localparam int SRC_CMPB = 7;
  localparam int SRC_WRAP = 8;
  localparam int SRC_INTR = 9;

  localparam logic [2:0] MODE_IDLE = 3'd0;
  localparam logic [2:0] MODE_EDS  = 3'd1;
  localparam logic [2:0] MODE_DS1  = 3'd2;
  localparam logic [2:0] MODE_DS2  = 3'd3;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_EDS    = 3'd2,
    ST_DS1    = 3'd3,
    ST_DS2    = 3'd4,
    ST_SETTLE = 3'd5
  } slp_state_t;

  function automatic logic mode_ok(input logic [2:0] m);
    return (m <= MODE_DS2);
  endfunction

  function automatic slp_state_t mode_to_state(input logic [2:0] m);
    case (m)
      MODE_IDLE: return ST_IDLE;
      MODE_EDS:  return ST_EDS;
      MODE_DS1:  return ST_DS1;
      default:   return ST_DS2;
    endcase
  endfunction

  // Sources allowed to end each state.
  function automatic logic [NSRC-1:0] wake_mask(input slp_state_t s);
    logic [NSRC-1:0] pins_dbg;
    logic [NSRC-1:0] timers;
    pins_dbg = '0;
    timers   = '0;
    for (int i = SRC_GPIO; i <= SRC_SYS; i++) pins_dbg[i] = 1'b1;
    for (int i = SRC_CMPA; i <= SRC_WRAP; i++) timers[i] = 1'b1;
    case (s)
      ST_IDLE: return NSRC'(1) << SRC_INTR;
      ST_EDS:  return pins_dbg | timers;
      ST_DS1:  return pins_dbg | timers;
      ST_DS2:  return pins_dbg;
      default: return '0;
    endcase
  endfunction

  function automatic logic settle_done(input logic [31:0] cnt);
    return (cnt == 32'd0);
  endfunction

  // Status update: clear first, new events on top.
  function automatic logic [NSRC-1:0] status_next(input logic [NSRC-1:0] cur,
                                                   input logic [NSRC-1:0] clr,
                                                   input logic [NSRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
  import pwr_sleep_pkg::*;
#(
  parameter int GPIO_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic              ser1_pin,
  input  logic              ser2_pin,
  input  logic              ext_irq,
  input  logic              dbg_pwrup_req,
  input  logic              sys_pwrup_req,
  input  logic              tmr_cmp_a,
  input  logic              tmr_cmp_b,
  input  logic              tmr_wrap,
  input  logic              irq_pending,
  input  logic [NSRC-1:0]   src_mask,
  output logic [NSRC-1:0]   fire,
  output logic              wake
);

  localparam int NPIN = 3;

  logic [GPIO_W-1:0] snap_gpio;
  logic [NPIN-1:0]   snap_pin;
  logic [NPIN-1:0]   pin_now;
  logic [NPIN-1:0]   pin_edge;
  logic              gpio_edge;
  logic [NSRC-1:0]   raw_evt;

  assign pin_now = {ext_irq, ser2_pin, ser1_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_gpio <= '0;
      snap_pin  <= '0;
    end else if (capture) begin
      snap_gpio <= gpio_in;
      snap_pin  <= pin_now;
    end
  end

  assign gpio_edge = |(gpio_in ^ snap_gpio);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin_edge
    assign pin_edge[p] = pin_now[p] ^ snap_pin[p];
  end

  always_comb begin
    raw_evt           = '0;
    raw_evt[SRC_GPIO] = gpio_edge;
    raw_evt[SRC_SER1] = pin_edge[0];
    raw_evt[SRC_SER2] = pin_edge[1];
    raw_evt[SRC_EXTI] = pin_edge[2];
    raw_evt[SRC_DBG]  = dbg_pwrup_req;
    raw_evt[SRC_SYS]  = sys_pwrup_req;
    raw_evt[SRC_CMPA] = tmr_cmp_a;
    raw_evt[SRC_CMPB] = tmr_cmp_b;
    raw_evt[SRC_WRAP] = tmr_wrap;
    raw_evt[SRC_INTR] = irq_pending;
  end

  assign fire = raw_evt & src_mask;
  assign wake = |fire;

endmodule

// File: rtl/pwr_wake_status.sv
module pwr_wake_status
  import pwr_sleep_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_data,
  input  logic [NSRC-1:0] set_vec,
  output logic [NSRC-1:0] status
);

  logic [NSRC-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_next(status, clr_eff, set_vec);
  end

endmodule

// File: rtl/pwr_clk_cfg.sv
module pwr_clk_cfg #(
  parameter int CFG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic             xtal32k_en,
  output logic             rc10k_en
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (wr) cfg_q <= wdata;
  end

  assign xtal32k_en = cfg_q[0];
  assign rc10k_en   = cfg_q[1];

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_sleep_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic [2:0]          sleep_mode,
  input  logic                wake,
  input  logic [SETTLE_W-1:0] settle_cnt,
  output slp_state_t          state,
  output logic                enter,
  output logic [NSRC-1:0]     src_mask,
  output logic                core_pwr_en,
  output logic                periph_rst,
  output logic                sleep_tmr_en,
  output logic                cpu_run
);

  logic [SETTLE_W-1:0] cnt_q;
  logic                in_deep;

  assign enter   = (state == ST_RUN) && sleep_req && mode_ok(sleep_mode);
  assign in_deep = (state == ST_EDS) || (state == ST_DS1) || (state == ST_DS2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt_q <= '0;
    end else begin
      case (state)
        ST_RUN:    if (enter) state <= mode_to_state(sleep_mode);
        ST_IDLE:   if (wake) state <= ST_RUN;
        ST_SETTLE: begin
          if (settle_done(32'(cnt_q))) state <= ST_RUN;
          else                         cnt_q <= cnt_q - 1'b1;
        end
        default: begin
          if (in_deep && wake) begin
            state <= ST_SETTLE;
            cnt_q <= settle_cnt;
          end
        end
      endcase
    end
  end

  assign src_mask     = wake_mask(state);
  assign core_pwr_en  = !((state == ST_DS1) || (state == ST_DS2));
  assign periph_rst   = in_deep || (state == ST_SETTLE);
  assign sleep_tmr_en = (state != ST_DS2);
  assign cpu_run      = (state == ST_RUN);

endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
  import pwr_sleep_pkg::*;
#(
  parameter int GPIO_W   = 24,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic [2:0]          sleep_mode,
  input  logic [SETTLE_W-1:0] settle_cnt,
  input  logic [GPIO_W-1:0]   gpio_in,
  input  logic                ser1_pin,
  input  logic                ser2_pin,
  input  logic                ext_irq,
  input  logic                dbg_pwrup_req,
  input  logic                sys_pwrup_req,
  input  logic                tmr_cmp_a,
  input  logic                tmr_cmp_b,
  input  logic                tmr_wrap,
  input  logic                irq_pending,
  input  logic                stat_clr_wr,
  input  logic [9:0]          stat_clr_data,
  input  logic                clk_cfg_wr,
  input  logic [1:0]          clk_cfg_wdata,
  output logic [9:0]          wake_status,
  output logic                core_pwr_en,
  output logic                periph_rst,
  output logic                sleep_tmr_en,
  output logic                cpu_run,
  output logic                xtal32k_en,
  output logic                rc10k_en
);

  slp_state_t      state;
  logic            enter;
  logic            wake;
  logic [NSRC-1:0] src_mask;
  logic [NSRC-1:0] wake_fire;

  pwr_seq_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .sleep_mode   (sleep_mode),
    .wake         (wake),
    .settle_cnt   (settle_cnt),
    .state        (state),
    .enter        (enter),
    .src_mask     (src_mask),
    .core_pwr_en  (core_pwr_en),
    .periph_rst   (periph_rst),
    .sleep_tmr_en (sleep_tmr_en),
    .cpu_run      (cpu_run)
  );

  pwr_wake_detect #(.GPIO_W(GPIO_W)) u_det (
    .clk           (clk),
    .rst_n         (rst_n),
    .capture       (enter),
    .gpio_in       (gpio_in),
    .ser1_pin      (ser1_pin),
    .ser2_pin      (ser2_pin),
    .ext_irq       (ext_irq),
    .dbg_pwrup_req (dbg_pwrup_req),
    .sys_pwrup_req (sys_pwrup_req),
    .tmr_cmp_a     (tmr_cmp_a),
    .tmr_cmp_b     (tmr_cmp_b),
    .tmr_wrap      (tmr_wrap),
    .irq_pending   (irq_pending),
    .src_mask      (src_mask),
    .fire          (wake_fire),
    .wake          (wake)
  );

  pwr_wake_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_wr   (stat_clr_wr),
    .clr_data (stat_clr_data),
    .set_vec  (wake_fire),
    .status   (wake_status)
  );

  pwr_clk_cfg #(.CFG_W(2)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (clk_cfg_wr),
    .wdata      (clk_cfg_wdata),
    .xtal32k_en (xtal32k_en),
    .rc10k_en   (rc10k_en)
  );

endmodule

// File: rtl/pwr_sleep_seq_chk.sv
module pwr_sleep_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic [2:0] sleep_mode,
  input logic [9:0] wake_status,
  input logic       stat_clr_wr,
  input logic       core_pwr_en,
  input logic       periph_rst,
  input logic       sleep_tmr_en,
  input logic       cpu_run,
  input logic [9:0] wake_fire
);

  // R10: running implies powered and out of reset
  assert_run_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> (core_pwr_en && !periph_rst));

  // R10: reset is released only after a cycle with core power on
  assert_release_after_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_rst) |-> $past(core_pwr_en));

  // R5: timer off means timer sources cannot fire
  assert_timer_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_tmr_en |-> (wake_fire[8:6] == 3'b000));

  // R5: timer off only while the core is off
  assert_tmr_off_core_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_tmr_en |-> !core_pwr_en);

  // R9: without a clear strobe no status bit drops
  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr_wr |=> ((wake_status & $past(wake_status)) == $past(wake_status)));

  // R8: a fired source is recorded on the next cycle
  assert_fire_recorded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_fire != 10'd0) |=> ((wake_status & $past(wake_fire)) == $past(wake_fire)));

  // R11: undefined mode keeps run
  assert_bad_mode_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && sleep_req && (sleep_mode > 3'd3)) |=> cpu_run);

  // R2: run is left only through a request
  assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && !sleep_req) |=> cpu_run);

endmodule

bind pwr_sleep_seq pwr_sleep_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req    (sleep_req),
  .sleep_mode   (sleep_mode),
  .wake_status  (wake_status),
  .stat_clr_wr  (stat_clr_wr),
  .core_pwr_en  (core_pwr_en),
  .periph_rst   (periph_rst),
  .sleep_tmr_en (sleep_tmr_en),
  .cpu_run      (cpu_run),
  .wake_fire    (wake_fire)
);

// File: tb/sim_pwr_sleep_seq.sv
`timescale 1ns/1ps
module sim_pwr_sleep_seq;

  localparam int GPIO_W   = 24;
  localparam int SETTLE_W = 8;
  localparam int NVEC     = 11;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                sleep_req = 1'b0;
  logic [2:0]          sleep_mode = '0;
  logic [SETTLE_W-1:0] settle_cnt = '0;
  logic [GPIO_W-1:0]   gpio_in = '0;
  logic                ser1_pin = 1'b0, ser2_pin = 1'b0, ext_irq = 1'b0;
  logic                dbg_pwrup_req = 1'b0, sys_pwrup_req = 1'b0;
  logic                tmr_cmp_a = 1'b0, tmr_cmp_b = 1'b0, tmr_wrap = 1'b0;
  logic                irq_pending = 1'b0;
  logic                stat_clr_wr = 1'b0;
  logic [9:0]          stat_clr_data = '0;
  logic                clk_cfg_wr = 1'b0;
  logic [1:0]          clk_cfg_wdata = '0;
  logic [9:0]          wake_status;
  logic                core_pwr_en, periph_rst, sleep_tmr_en, cpu_run;
  logic                xtal32k_en, rc10k_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  pwr_sleep_seq #(.GPIO_W(GPIO_W), .SETTLE_W(SETTLE_W)) u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // {mode[2:0], stim[9:0], wake, expected status[9:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {3'd0, 10'h001, 1'b0, 10'h000},  // R2 idle ignores GPIO
    {3'd0, 10'h200, 1'b1, 10'h200},  // R2 idle wakes on interrupt
    {3'd1, 10'h080, 1'b1, 10'h080},  // R3 emulated, compare B
    {3'd1, 10'h004, 1'b1, 10'h004},  // R3 emulated, serial pin 2
    {3'd1, 10'h200, 1'b0, 10'h000},  // R3 emulated ignores idle interrupt
    {3'd2, 10'h100, 1'b1, 10'h100},  // R4 deep 1, wrap
    {3'd2, 10'h003, 1'b1, 10'h003},  // R8 two sources at once
    {3'd3, 10'h1C0, 1'b0, 10'h000},  // R5 deep 2 ignores all timers
    {3'd3, 10'h008, 1'b1, 10'h008},  // R6 deep 2, external line edge
    {3'd3, 10'h120, 1'b1, 10'h020},  // R5 timer masked beside system req
    {3'd2, 10'h010, 1'b1, 10'h010}   // R7 deep 1, debug request
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic request(input logic [2:0] m);
    sleep_req  = 1'b1;
    sleep_mode = m;
    tick();
    sleep_req  = 1'b0;
  endtask

  task automatic wait_run(input string req);
    int k = 0;
    while (!cpu_run && k < 300) begin
      tick();
      k++;
    end
    chk(req, 32'(cpu_run), 32'd1);
  endtask

  task automatic clear_all();
    stat_clr_wr   = 1'b1;
    stat_clr_data = 10'h3FF;
    tick();
    stat_clr_wr   = 1'b0;
  endtask

  task automatic apply(input logic [9:0] s, input int idx);
    if (s[0]) gpio_in[(idx * 5) % GPIO_W] = ~gpio_in[(idx * 5) % GPIO_W];
    if (s[1]) ser1_pin = ~ser1_pin;
    if (s[2]) ser2_pin = ~ser2_pin;
    if (s[3]) ext_irq  = ~ext_irq;
    dbg_pwrup_req = s[4];
    sys_pwrup_req = s[5];
    tmr_cmp_a     = s[6];
    tmr_cmp_b     = s[7];
    tmr_wrap      = s[8];
    irq_pending   = s[9];
  endtask

  task automatic drop_levels();
    dbg_pwrup_req = 1'b0;
    sys_pwrup_req = 1'b0;
    tmr_cmp_a = 1'b0;
    tmr_cmp_b = 1'b0;
    tmr_wrap  = 1'b0;
    irq_pending = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 cpu_run", 32'(cpu_run), 32'd1);
    chk("R1 core_pwr_en", 32'(core_pwr_en), 32'd1);
    chk("R1 periph_rst", 32'(periph_rst), 32'd0);
    chk("R1 sleep_tmr_en", 32'(sleep_tmr_en), 32'd1);
    chk("R1 wake_status", 32'(wake_status), 32'd0);
    chk("R1 clk cfg", 32'({rc10k_en, xtal32k_en}), 32'd0);

    settle_cnt = 8'd2;
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] m;
      logic [9:0] s;
      logic       w;
      logic [9:0] e;
      {m, s, w, e} = VEC[i];
      request(m);
      chk($sformatf("R2-mode%0d cpu_run asleep", m), 32'(cpu_run), 32'd0);
      chk("R4 core_pwr_en per mode", 32'(core_pwr_en), 32'(m < 3'd2));
      chk("R3 periph_rst per mode", 32'(periph_rst), 32'(m != 3'd0));
      chk("R5 sleep_tmr_en per mode", 32'(sleep_tmr_en), 32'(m != 3'd3));
      apply(s, i);
      tick();
      drop_levels();
      if (w && m == 3'd0) begin
        chk("R2 idle returns at once", 32'(cpu_run), 32'd1);
      end else if (w) begin
        chk("R10 settle: powered, in reset", 32'({cpu_run, core_pwr_en, periph_rst}), 32'b011);
      end else begin
        chk("R5 ignored source keeps sleep", 32'(cpu_run), 32'd0);
      end
      chk("R8 status after vector", 32'(wake_status), 32'(e));
      if (!w) begin
        if (m == 3'd0) irq_pending = 1'b1;
        else           dbg_pwrup_req = 1'b1;
        tick();
        drop_levels();
      end
      wait_run("R10 back to run");
      clear_all();
    end

    // R11 undefined modes
    request(3'd5);
    chk("R11 mode 5 ignored", 32'({cpu_run, core_pwr_en, periph_rst}), 32'b110);
    request(3'd7);
    chk("R11 mode 7 ignored", 32'(cpu_run), 32'd1);

    // R12 clock configuration
    clk_cfg_wr = 1'b1; clk_cfg_wdata = 2'b01; tick(); clk_cfg_wr = 1'b0;
    chk("R12 bit0 crystal", 32'({rc10k_en, xtal32k_en}), 32'b01);
    clk_cfg_wr = 1'b1; clk_cfg_wdata = 2'b10; tick(); clk_cfg_wr = 1'b0;
    chk("R12 bit1 RC", 32'({rc10k_en, xtal32k_en}), 32'b10);

    // R6 steady level does not wake, change does
    ser1_pin = 1'b1;
    tick();
    request(3'd2);
    repeat (3) tick();
    chk("R6 steady pin keeps sleep", 32'(cpu_run), 32'd0);
    chk("R6 no status for steady pin", 32'(wake_status), 32'd0);
    ser1_pin = 1'b0;
    tick();
    chk("R6 pin change wakes", 32'(wake_status), 32'h002);
    wait_run("R6 run after pin wake");
    clear_all();

    // R7 level already high at entry wakes
    dbg_pwrup_req = 1'b1;
    request(3'd3);
    chk("R7 entered deep 2", 32'(core_pwr_en), 32'd0);
    tick();
    dbg_pwrup_req = 1'b0;
    chk("R7 held request wakes", 32'(core_pwr_en), 32'd1);
    wait_run("R7 run");
    clear_all();

    // R10 settle length, count latched at wake
    settle_cnt = 8'd3;
    request(3'd2);
    tmr_wrap = 1'b1;
    tick();
    tmr_wrap = 1'b0;
    settle_cnt = 8'd0;
    begin
      int n = 0;
      int bad = 0;
      while (!cpu_run && n < 50) begin
        if (!(core_pwr_en && periph_rst)) bad++;
        n++;
        tick();
      end
      chk("R10 settle cycles", 32'(n), 32'd4);
      chk("R10 controls during settle", 32'(bad), 32'd0);
    end
    chk("R10 reset released at run", 32'(periph_rst), 32'd0);
    clear_all();

    // R9 set wins over clear in the same cycle
    settle_cnt = 8'd1;
    request(3'd3);
    sys_pwrup_req = 1'b1;
    stat_clr_wr = 1'b1;
    stat_clr_data = 10'h3FF;
    tick();
    sys_pwrup_req = 1'b0;
    stat_clr_wr = 1'b0;
    chk("R9 set beats clear", 32'(wake_status), 32'h020);
    wait_run("R9 run");

    // R9 partial clear
    request(3'd2);
    dbg_pwrup_req = 1'b1;
    tick();
    dbg_pwrup_req = 1'b0;
    chk("R8 sticky plus new bit", 32'(wake_status), 32'h030);
    wait_run("R9 run 2");
    stat_clr_wr = 1'b1;
    stat_clr_data = 10'h010;
    tick();
    stat_clr_wr = 1'b0;
    chk("R9 partial clear", 32'(wake_status), 32'h020);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule